// File: doc/BRIEF.md
# External Pin Interrupt Port

This block watches eight general-purpose pins and turns selected activity on them into interrupt requests for a downstream interrupt controller. Each pin has a two-bit sensing code that chooses between active-low level sensing and detection of rising, falling or any transitions. Pin inputs are brought into the clock domain through a two-flop synchronizer. A third stage holds the previous synchronized sample, and edges are found by comparing it with the current one.

Software configures the port over a simple register bus. One register holds the sensing codes. Two more hold a direction mask and an enable mask. A fourth holds the pin output data. Detected edges are latched in a flag register that is cleared by writing ones. A pin raises its request line only when its flag is set, its enable bit is set and it is configured as an input. The block also reports the interrupt vector of the lowest-numbered requesting pin. That vector is a fixed base plus the pin index.

Top module: `extirq_port`

## Requirements
- R1: After reset the sensing, direction, enable, output-data and flag registers all read zero, pin_oe is zero and no request is raised, so every pin is a level-low input with interrupts disabled.
- R2: The bus writes and reads back the 16-bit sensing register at address 0, the direction mask at address 1, the enable mask at address 2 and the output data at address 3 (low 8 bits). pin_oe follows the direction mask and pin_out follows the output data.
- R3: Pin n's sensing code sits at bits [2n+1:2n] of the sensing register. Code 01 flags a low-to-high change, 10 flags a high-to-low change and 11 flags both. The flag bit becomes visible on the third rising clock edge after the pin changes.
- R4: Writing to the flag register at address 4 clears each edge-mode flag whose data bit is 1. Bits written as 0 leave their flags unchanged. An edge detected in the same cycle as the clear leaves the flag set.
- R5: With code 00 a pin's flag mirrors its synchronized input being low. A clear write has no effect while the pin stays low, and the flag drops once the pin is seen high.
- R6: irq_req[n] is 1 exactly when flag n is set, enable bit n is 1 and direction bit n is 0 (input). Flags are still recorded while the enable bit is 0.
- R7: irq_any is 1 when any request is active, and irq_vector then equals VEC_BASE (default 64) plus the index of the lowest-numbered requesting pin.
- R8: Address 5 reads the synchronized pin levels. Writes to address 5 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Output data to the pads |
| pin_oe | output | 8 | Output enable per pin (1 = drive) |
| irq_req | output | 8 | Interrupt request per pin |
| irq_any | output | 1 | At least one request active |
| irq_vector | output | 8 | Vector of the lowest-numbered active request |

## Verification
The hardest case to reach is an edge detected in the very cycle a clear write for the same flag is accepted. Hitting it requires placing the bus write exactly on the third clock edge after the pin toggles. The bench counts the synchronizer stages from a pin change made at a falling clock edge and raises the write strobe only for the cycle that ends on that third edge. A second hard case is a level-mode flag that must resist a clear write while the pin is held low. It is reached by holding the pin low across the write and then reading the flag register.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    typedef enum logic [1:0] {
        SNS_LEVEL = 2'b00,
        SNS_RISE  = 2'b01,
        SNS_FALL  = 2'b10,
        SNS_BOTH  = 2'b11
    } sense_e;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_SENSE = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_DIR   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_EN    = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_DOUT  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_FLAG  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_PINS  = 3'd5;

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int   W       = 8,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);

    typedef struct packed {
        logic [W-1:0] st1;
        logic [W-1:0] st2;
        logic [W-1:0] st3;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.st1 = d;
        s_d.st2 = s_q.st1;
        s_d.st3 = s_q.st2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= {(3*W){RST_VAL}};
        end else begin
            s_q <= s_d;
        end
    end

    assign lvl      = s_q.st2;
    assign lvl_prev = s_q.st3;

endmodule

// File: rtl/extirq_flag.sv
module extirq_flag
    import extirq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  sense_e mode,
    input  logic   cur,
    input  logic   prev,
    input  logic   clr,
    output logic   flag
);

    logic flag_d, flag_q;
    logic hit;

    always_comb begin
        hit = 1'b0;
        unique case (mode)
            SNS_RISE: hit = cur & ~prev;
            SNS_FALL: hit = ~cur & prev;
            SNS_BOTH: hit = cur ^ prev;
            default:  hit = 1'b0;
        endcase
        if (mode == SNS_LEVEL) begin
            flag_d = ~cur;
        end else begin
            flag_d = (flag_q & ~clr) | hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/extirq_port.sv
module extirq_port
    import extirq_pkg::*;
#(
    parameter int NPIN     = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [2*NPIN-1:0]     bus_wdata,
    output logic [2*NPIN-1:0]     bus_rdata,
    input  logic [NPIN-1:0]       pin_in,
    output logic [NPIN-1:0]       pin_out,
    output logic [NPIN-1:0]       pin_oe,
    output logic [NPIN-1:0]       irq_req,
    output logic                  irq_any,
    output logic [VEC_W-1:0]      irq_vector
);

    localparam int SENSE_W = 2 * NPIN;
    localparam int DATA_W  = SENSE_W;
    localparam int IDX_W   = (NPIN > 1) ? $clog2(NPIN) : 1;
    localparam int PAD_W   = DATA_W - NPIN;

    typedef struct packed {
        logic [SENSE_W-1:0] sense;
        logic [NPIN-1:0]    dir;
        logic [NPIN-1:0]    en;
        logic [NPIN-1:0]    dout;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [NPIN-1:0]  lvl;
    logic [NPIN-1:0]  lvl_prev;
    logic [NPIN-1:0]  flag_q;
    logic [NPIN-1:0]  clr;
    logic [IDX_W-1:0] win_idx;

    // configuration registers
    always_comb begin
        cfg_d = cfg_q;
        if (bus_wr) begin
            unique case (bus_addr)
                ADR_SENSE: cfg_d.sense = bus_wdata[SENSE_W-1:0];
                ADR_DIR:   cfg_d.dir   = bus_wdata[NPIN-1:0];
                ADR_EN:    cfg_d.en    = bus_wdata[NPIN-1:0];
                ADR_DOUT:  cfg_d.dout  = bus_wdata[NPIN-1:0];
                default:   cfg_d       = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign clr = (bus_wr && bus_addr == ADR_FLAG) ? bus_wdata[NPIN-1:0] : '0;

    extirq_sync #(
        .W       (NPIN),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .d        (pin_in),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        extirq_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (sense_e'(cfg_q.sense[2*g+1:2*g])),
            .cur   (lvl[g]),
            .prev  (lvl_prev[g]),
            .clr   (clr[g]),
            .flag  (flag_q[g])
        );
    end

    // request gating and lowest-index selection
    always_comb begin
        irq_req = flag_q & cfg_q.en & ~cfg_q.dir;
        irq_any = 1'b0;
        win_idx = '0;
        for (int i = NPIN - 1; i >= 0; i--) begin
            if (irq_req[i]) begin
                irq_any = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
        irq_vector = VEC_W'(VEC_BASE) + VEC_W'(win_idx);
    end

    // register readback
    always_comb begin
        unique case (bus_addr)
            ADR_SENSE: bus_rdata = cfg_q.sense;
            ADR_DIR:   bus_rdata = {{PAD_W{1'b0}}, cfg_q.dir};
            ADR_EN:    bus_rdata = {{PAD_W{1'b0}}, cfg_q.en};
            ADR_DOUT:  bus_rdata = {{PAD_W{1'b0}}, cfg_q.dout};
            ADR_FLAG:  bus_rdata = {{PAD_W{1'b0}}, flag_q};
            ADR_PINS:  bus_rdata = {{PAD_W{1'b0}}, lvl};
            default:   bus_rdata = '0;
        endcase
    end

    assign pin_out = cfg_q.dout;
    assign pin_oe  = cfg_q.dir;

endmodule

// File: rtl/extirq_port_chk.sv
module extirq_port_chk
    import extirq_pkg::*;
#(
    parameter int NPIN     = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [2*NPIN-1:0]     sense,
    input logic [NPIN-1:0]       dir,
    input logic [NPIN-1:0]       en,
    input logic [NPIN-1:0]       flag,
    input logic [NPIN-1:0]       lvl,
    input logic [NPIN-1:0]       prev,
    input logic                  bus_wr,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [2*NPIN-1:0]     bus_wdata,
    input logic [NPIN-1:0]       irq_req,
    input logic                  irq_any,
    input logic [VEC_W-1:0]      irq_vector
);

    for (genvar g = 0; g < NPIN; g++) begin : g_chk
        // R3: a rising edge in rising mode sets the flag one cycle later
        a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(sense[2*g+1:2*g]) == SNS_RISE && $past(lvl[g] & ~prev[g])) |-> flag[g]);

        // R4: an edge-mode flag only drops after a clear write of its bit
        a_r4_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(flag[g]) && $past(sense[2*g+1:2*g]) != SNS_LEVEL)
            |-> $past(bus_wr && bus_addr == ADR_FLAG && bus_wdata[g]));

        // R5: level mode flag mirrors the synchronized low level
        a_r5_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(sense[2*g+1:2*g]) == SNS_LEVEL) |-> (flag[g] == !$past(lvl[g])));

        // R6: a request needs a flag, an enable and input direction
        a_r6_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[g] |-> (flag[g] && en[g] && !dir[g]));

        // R7: the reported vector is never above a requesting pin
        a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_any && irq_req[g]) |-> (int'(irq_vector) <= VEC_BASE + g));
    end

    // R7: the vector stays within the port's range and any tracks the requests
    a_r7_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> (int'(irq_vector) >= VEC_BASE && int'(irq_vector) < VEC_BASE + NPIN));

    a_r7_any_match: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == (irq_req != '0));

endmodule

bind extirq_port extirq_port_chk #(
    .NPIN     (NPIN),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sense      (cfg_q.sense),
    .dir        (cfg_q.dir),
    .en         (cfg_q.en),
    .flag       (flag_q),
    .lvl        (lvl),
    .prev       (lvl_prev),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .irq_req    (irq_req),
    .irq_any    (irq_any),
    .irq_vector (irq_vector)
);

// File: tb/extirq_port_test.sv
module extirq_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int TPIN       = 5;

    // {mode[1:0], start level, end level, expected flag}
    localparam logic [4:0] TBL [8] = '{
        5'b01_0_1_1,
        5'b01_1_0_0,
        5'b10_1_0_1,
        5'b10_0_1_0,
        5'b11_0_1_1,
        5'b11_1_0_1,
        5'b01_1_1_0,
        5'b11_0_0_0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [7:0]  pin_in = 8'hFF;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;
    logic [7:0]  irq_req;
    logic        irq_any;
    logic [7:0]  irq_vector;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic [15:0] rv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    extirq_port uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .irq_req    (irq_req),
        .irq_any    (irq_any),
        .irq_vector (irq_vector)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(2);

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), rv);
            check("R1 reset register", 32'(rv), 32'h0);
        end
        check("R1 reset irq_req", 32'(irq_req), 32'h0);
        check("R1 reset pin_oe", 32'(pin_oe), 32'h0);

        // R2: register write and readback
        wr(3'd0, 16'hA5C3);
        rd(3'd0, rv);
        check("R2 sense readback", 32'(rv), 32'hA5C3);
        wr(3'd1, 16'h000F);
        rd(3'd1, rv);
        check("R2 dir readback", 32'(rv), 32'h0F);
        check("R2 pin_oe", 32'(pin_oe), 32'h0F);
        wr(3'd3, 16'h003C);
        rd(3'd3, rv);
        check("R2 dout readback", 32'(rv), 32'h3C);
        check("R2 pin_out", 32'(pin_out), 32'h3C);
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h0000);

        // R3: table of edge modes on one pin
        for (int k = 0; k < 8; k++) begin
            wr(3'd0, 16'(TBL[k][4:3]) << (2 * TPIN));
            pin_in[TPIN] = TBL[k][2];
            settle(5);
            wr(3'd4, 16'h00FF);
            pin_in[TPIN] = TBL[k][1];
            settle(5);
            rd(3'd4, rv);
            check("R3 edge table", 32'(rv), 32'(TBL[k][0]) << TPIN);
        end
        pin_in[TPIN] = 1'b1;
        wr(3'd0, 16'h0000);
        settle(5);

        // R3: latency of a rising edge on pin 0
        wr(3'd0, 16'h0001);
        pin_in[0] = 1'b0;
        settle(5);
        wr(3'd4, 16'h00FF);
        pin_in[0] = 1'b1;
        settle(2);
        rd(3'd4, rv);
        check("R3 flag not yet after two edges", 32'(rv[0]), 32'h0);
        settle(1);
        rd(3'd4, rv);
        check("R3 flag after third edge", 32'(rv[0]), 32'h1);

        // R4: write-one-to-clear
        wr(3'd4, 16'h0000);
        rd(3'd4, rv);
        check("R4 zero write keeps flag", 32'(rv[0]), 32'h1);
        wr(3'd4, 16'h0001);
        rd(3'd4, rv);
        check("R4 one write clears flag", 32'(rv[0]), 32'h0);
        pin_in[0] = 1'b0;
        settle(5);
        wr(3'd4, 16'h00FF);
        pin_in[0] = 1'b1;
        settle(2);
        bus_wr    = 1'b1;
        bus_addr  = 3'd4;
        bus_wdata = 16'h0001;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(3'd4, rv);
        check("R4 edge beats same-cycle clear", 32'(rv[0]), 32'h1);
        wr(3'd4, 16'h0001);

        // R5: level-low sensing on pin 1
        pin_in[1] = 1'b0;
        settle(4);
        rd(3'd4, rv);
        check("R5 level flag set", 32'(rv[1]), 32'h1);
        wr(3'd4, 16'h0002);
        rd(3'd4, rv);
        check("R5 clear ignored while low", 32'(rv[1]), 32'h1);
        pin_in[1] = 1'b1;
        settle(4);
        rd(3'd4, rv);
        check("R5 flag drops when high", 32'(rv[1]), 32'h0);

        // R6: gating by enable and direction
        pin_in[1] = 1'b0;
        settle(4);
        check("R6 disabled pin no request", 32'(irq_req), 32'h0);
        rd(3'd4, rv);
        check("R6 flag kept while disabled", 32'(rv[1]), 32'h1);
        wr(3'd2, 16'h0002);
        check("R6 enabled input requests", 32'(irq_req), 32'h02);
        wr(3'd1, 16'h0002);
        check("R6 output pin no request", 32'(irq_req), 32'h0);
        wr(3'd1, 16'h0000);

        // R7: vector of lowest requesting pin
        pin_in[6] = 1'b0;
        wr(3'd2, 16'h0042);
        settle(4);
        check("R7 any with two requests", 32'(irq_any), 32'h1);
        check("R7 vector pin 1", 32'(irq_vector), 32'd65);
        pin_in[1] = 1'b1;
        settle(4);
        check("R7 vector pin 6", 32'(irq_vector), 32'd70);
        pin_in[6] = 1'b1;
        settle(4);
        check("R7 any idle", 32'(irq_any), 32'h0);

        // R8: pin level readback, writes ignored
        pin_in = 8'hA5;
        settle(3);
        rd(3'd5, rv);
        check("R8 pin levels", 32'(rv), 32'hA5);
        wr(3'd5, 16'h00FF);
        rd(3'd5, rv);
        check("R8 write to pin levels ignored", 32'(rv), 32'hA5);
        rd(3'd2, rv);
        check("R8 enable unchanged", 32'(rv), 32'h42);
        rd(3'd0, rv);
        check("R8 sense unchanged", 32'(rv), 32'h0001);
        pin_in = 8'hFF;
        settle(4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule